// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block is the per-core part of an interrupt controller. It keeps a record of up to 256 interrupt vectors in three bit sets. The first holds the vectors waiting for service. The second holds the vectors the core has taken and not yet finished. The third records, for each vector, whether it arrived as level-triggered or edge-triggered. A source injects a vector together with its trigger kind. The block compares the priority class of the highest waiting vector, which is its upper four bits, with the current processor priority. It offers that vector to the core only when the class is strictly higher.

The core takes the offered vector with an acknowledge strobe. When the handler finishes, it signals end-of-interrupt. The block then retires the highest in-service vector and reports which vector it was and whether it was level-triggered, so that an upstream router can re-arm a level source. Software sets a task priority through a write port. The processor priority follows from that task priority and from the class of the highest in-service vector. The whole controller works only while a hardware enable input and a software enable bit are both set.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After a synchronous reset the pending, in-service and trigger sets, the task priority and the software enable are all cleared; `proc_prio` reads 0x00 and `irq_valid` is low.
- R2: The controller is enabled only when `hw_en` is 1 and the last value written on the configuration port had bit 8 set. While disabled, injections are dropped (`inj_ok` low, no vector recorded) and `irq_valid` is low.
- R3: An enabled injection of vector V sets V's pending bit. `inj_ok` is 1 only if that bit was clear before. If the bit was already set and the request is level, the trigger bit of V is left unchanged. Otherwise the trigger bit is set for level (`inj_level`=1) and cleared for edge (`inj_level`=0).
- R4: Vectors 0x00 to 0x0F are reserved. Injecting one drives `inj_err` high in the same cycle, leaves `inj_ok` low and records nothing.
- R5: With T the task priority and S the highest in-service vector (0 when none), `proc_prio` equals T when T[7:4] >= S[7:4], and equals {S[7:4],4'h0} otherwise. A write on the task priority port takes effect on the next cycle.
- R6: `irq_vec` is the highest pending vector. `irq_valid` is high exactly when the controller is enabled and {irq_vec[7:4],4'h0} is strictly greater than `proc_prio`.
- R7: An `ack` while `irq_valid` is high moves `irq_vec` from the pending set to the in-service set. An `ack` while `irq_valid` is low has no effect.
- R8: An `eoi` while a vector is in service raises `eoi_valid` in the same cycle, with `eoi_vec` the highest in-service vector and `eoi_level` its trigger bit. It clears that vector's in-service and trigger bits. An `eoi` with nothing in service leaves `eoi_valid` low and changes no state.
- R9: When injection, acknowledge and end-of-interrupt fall in one cycle, they take effect in that order. An end-of-interrupt paired with an effective acknowledge retires the vector just acknowledged. An injection of the vector being acknowledged leaves it out of the pending set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Hardware enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration data; bit 8 is the software enable |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| inj_valid | input | 1 | Vector injection request |
| inj_vec | input | 8 | Injected vector number |
| inj_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| inj_ok | output | 1 | Injection created a new pending request |
| inj_err | output | 1 | Injection named a reserved vector |
| irq_valid | output | 1 | A deliverable vector is offered |
| irq_vec | output | 8 | Highest pending vector |
| proc_prio | output | 8 | Current processor priority |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_valid | output | 1 | A vector was retired this cycle |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |

## Verification
Acknowledge and end-of-interrupt can land in the same cycle, and so can an injection and an acknowledge of the same vector. Both pairings are driven on purpose. The first appears in the stimulus table with one vector pending and nothing in service; the expected result is both sets empty and priority back to 0x00. The second appears in a directed test that re-injects the vector currently on offer while acknowledging it; the expected result is `inj_ok` low, the vector present only in the in-service set, and `proc_prio` at its class.

// File: rtl/vpc_pkg.sv
// Package: shared defaults and the trigger-kind encoding for the vector controller.
// Assumes: vectors are numbered 0..2**VEC_W-1 and are held in 32-bit words.
package vpc_pkg;
    localparam int VEC_W      = 8;
    localparam int WORD_W     = 32;
    localparam int CLASS_W    = 4;
    localparam int RSVD_LIMIT = 16;
    localparam int CFG_W      = 10;
    localparam int SW_EN_BIT  = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/vpc_msb_find.sv
// Module: finds the highest set bit in a vector bitmap.
// The bitmap is treated as words of WORD_W bits. Each word reports whether it is
// non-empty and its top bit position; the highest non-empty word then wins.
// Assumes: 2**VEC_W is a multiple of WORD_W and WORD_W is a power of two.
module vpc_msb_find #(
    parameter int VEC_W  = vpc_pkg::VEC_W,
    parameter int WORD_W = vpc_pkg::WORD_W
) (
    input  logic [(1<<VEC_W)-1:0] bits,
    output logic                  hit,
    output logic [VEC_W-1:0]      idx
);
    localparam int NUM_BITS   = 1 << VEC_W;
    localparam int NUM_WORDS  = NUM_BITS / WORD_W;
    localparam int BIT_IDX_W  = $clog2(WORD_W);
    localparam int WORD_IDX_W = VEC_W - BIT_IDX_W;

    logic [NUM_WORDS-1:0]           word_any;
    logic [NUM_WORDS*BIT_IDX_W-1:0] word_msb;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [BIT_IDX_W-1:0] msb_w;

        // Purpose: flag a non-empty word.
        assign word_any[w] = |bits[w*WORD_W +: WORD_W];

        // Purpose: position of the top set bit inside this word (later bits win).
        always_comb begin
            msb_w = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) msb_w = BIT_IDX_W'(b);
            end
        end

        assign word_msb[w*BIT_IDX_W +: BIT_IDX_W] = msb_w;
    end

    // Purpose: choose the highest non-empty word and join word and bit indices.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) begin
                hit = 1'b1;
                idx = {WORD_IDX_W'(w), word_msb[w*BIT_IDX_W +: BIT_IDX_W]};
            end
        end
    end
endmodule

// File: rtl/vpc_prio_calc.sv
// Module: processor priority and deliverability decision.
// The priority takes the task priority unless the top in-service class is higher,
// in which case it becomes that class with a zero low part. A pending vector is
// deliverable when its class, zero-extended, is strictly above the priority.
// Assumes: top in-service and top pending indices are meaningful only with their hit flags.
module vpc_prio_calc #(
    parameter int VEC_W   = vpc_pkg::VEC_W,
    parameter int CLASS_W = vpc_pkg::CLASS_W
) (
    input  logic [VEC_W-1:0] task_prio,
    input  logic             isr_hit,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             irr_hit,
    input  logic [VEC_W-1:0] irr_top,
    output logic [VEC_W-1:0] proc_prio,
    output logic             deliver
);
    localparam int SUB_W = VEC_W - CLASS_W;

    logic [CLASS_W-1:0] task_cls;
    logic [CLASS_W-1:0] isr_cls;
    logic [VEC_W-1:0]   pend_cls;

    // Purpose: pick out the priority classes.
    assign task_cls = task_prio[VEC_W-1:SUB_W];
    assign isr_cls  = isr_hit ? isr_top[VEC_W-1:SUB_W] : '0;
    assign pend_cls = {irr_top[VEC_W-1:SUB_W], {SUB_W{1'b0}}};

    // Purpose: processor priority from task priority and in-service class.
    always_comb begin
        if (task_cls >= isr_cls) proc_prio = task_prio;
        else                     proc_prio = {isr_cls, {SUB_W{1'b0}}};
    end

    // Purpose: the highest pending vector may go only above the current priority.
    assign deliver = irr_hit && (pend_cls > proc_prio);
endmodule

// File: rtl/vpc_vec_bank.sv
// Module: storage for the pending, in-service and trigger bit sets.
// Applies injection, then acknowledge, then end-of-interrupt, each on the result
// of the previous step, and registers the outcome.
// Assumes: the caller has already gated each request (enable, reserved range,
// presence of a vector); this module performs the bit updates only.
module vpc_vec_bank #(
    parameter int VEC_W = vpc_pkg::VEC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inj_do,
    input  logic [VEC_W-1:0]      inj_vec,
    input  logic                  inj_level,
    input  logic                  ack_do,
    input  logic [VEC_W-1:0]      ack_vec,
    input  logic                  eoi_do,
    input  logic [VEC_W-1:0]      eoi_vec,
    output logic [(1<<VEC_W)-1:0] irr,
    output logic [(1<<VEC_W)-1:0] isr,
    output logic                  inj_was_set,
    output logic                  eoi_trig
);
    localparam int NUM_BITS = 1 << VEC_W;

    logic [NUM_BITS-1:0] tmr;
    logic [NUM_BITS-1:0] irr_a, tmr_a;
    logic [NUM_BITS-1:0] irr_b, isr_b;
    logic [NUM_BITS-1:0] isr_c, tmr_c;

    // Purpose: earlier state of the pending bit named by the injection.
    assign inj_was_set = irr[inj_vec];

    // Purpose: step 1, injection.
    always_comb begin
        irr_a = irr;
        tmr_a = tmr;
        if (inj_do) begin
            if (!(irr[inj_vec] && inj_level)) tmr_a[inj_vec] = inj_level;
            irr_a[inj_vec] = 1'b1;
        end
    end

    // Purpose: step 2, acknowledge moves the vector from pending to in-service.
    always_comb begin
        irr_b = irr_a;
        isr_b = isr;
        if (ack_do) begin
            irr_b[ack_vec] = 1'b0;
            isr_b[ack_vec] = 1'b1;
        end
    end

    // Purpose: trigger kind of the retired vector as seen after injection.
    assign eoi_trig = tmr_a[eoi_vec];

    // Purpose: step 3, end-of-interrupt retires the vector and its trigger bit.
    always_comb begin
        isr_c = isr_b;
        tmr_c = tmr_a;
        if (eoi_do) begin
            isr_c[eoi_vec] = 1'b0;
            tmr_c[eoi_vec] = 1'b0;
        end
    end

    // Purpose: register the three bit sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= irr_b;
            isr <= isr_c;
            tmr <= tmr_c;
        end
    end
endmodule

// File: rtl/vec_prio_ctrl.sv
// Module: prioritized interrupt vector controller (top).
// Holds the enables and task priority, finds the top pending and top in-service
// vectors, derives the processor priority, offers the deliverable vector, and
// handles injection, acknowledge and end-of-interrupt.
// Assumes: single clock domain; ack is honoured only while irq_valid is high.
module vec_prio_ctrl #(
    parameter int VEC_W      = vpc_pkg::VEC_W,
    parameter int WORD_W     = vpc_pkg::WORD_W,
    parameter int CLASS_W    = vpc_pkg::CLASS_W,
    parameter int RSVD_LIMIT = vpc_pkg::RSVD_LIMIT,
    parameter int CFG_W      = vpc_pkg::CFG_W,
    parameter int SW_EN_BIT  = vpc_pkg::SW_EN_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             inj_valid,
    input  logic [VEC_W-1:0] inj_vec,
    input  logic             inj_level,
    output logic             inj_ok,
    output logic             inj_err,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vec,
    output logic [VEC_W-1:0] proc_prio,
    input  logic             ack,
    input  logic             eoi,
    output logic             eoi_valid,
    output logic [VEC_W-1:0] eoi_vec,
    output logic             eoi_level
);
    localparam int NUM_BITS = 1 << VEC_W;

    logic                sw_en_q;
    logic [VEC_W-1:0]    task_q;
    logic                enabled;
    logic                inj_rsvd;
    logic                inj_do;
    logic                inj_was_set;
    logic                ack_do;
    logic                eoi_do;
    logic                eoi_trig;
    logic                deliver;
    logic [NUM_BITS-1:0] irr;
    logic [NUM_BITS-1:0] isr;
    logic                irr_hit, isr_hit;
    logic [VEC_W-1:0]    irr_top, isr_top;
    vpc_pkg::trig_e      eoi_kind;

    // Purpose: software enable bit and task priority registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en_q <= 1'b0;
            task_q  <= '0;
        end else begin
            if (cfg_we) sw_en_q <= cfg_wdata[SW_EN_BIT];
            if (tpr_we) task_q  <= tpr_wdata;
        end
    end

    // Purpose: overall enable and the injection gate.
    assign enabled  = hw_en && sw_en_q;
    assign inj_rsvd = inj_vec < VEC_W'(RSVD_LIMIT);
    assign inj_do   = inj_valid && enabled && !inj_rsvd;
    assign inj_ok   = inj_do && !inj_was_set;
    assign inj_err  = inj_valid && inj_rsvd;

    // Purpose: highest pending vector.
    vpc_msb_find #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_find_irr (
        .bits (irr),
        .hit  (irr_hit),
        .idx  (irr_top)
    );

    // Purpose: highest in-service vector.
    vpc_msb_find #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_find_isr (
        .bits (isr),
        .hit  (isr_hit),
        .idx  (isr_top)
    );

    // Purpose: processor priority and delivery decision.
    vpc_prio_calc #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
        .task_prio (task_q),
        .isr_hit   (isr_hit),
        .isr_top   (isr_top),
        .irr_hit   (irr_hit),
        .irr_top   (irr_top),
        .proc_prio (proc_prio),
        .deliver   (deliver)
    );

    // Purpose: offer, acknowledge and end-of-interrupt control.
    assign irq_valid = enabled && deliver;
    assign irq_vec   = irr_top;
    assign ack_do    = ack && irq_valid;
    assign eoi_do    = eoi && (ack_do || isr_hit);
    assign eoi_vec   = ack_do ? irr_top : isr_top;
    assign eoi_valid = eoi_do;
    assign eoi_kind  = vpc_pkg::trig_e'(eoi_trig);
    assign eoi_level = eoi_do && (eoi_kind == vpc_pkg::TRIG_LEVEL);

    // Purpose: bit set storage with ordered updates.
    vpc_vec_bank #(.VEC_W(VEC_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .inj_do      (inj_do),
        .inj_vec     (inj_vec),
        .inj_level   (inj_level),
        .ack_do      (ack_do),
        .ack_vec     (irr_top),
        .eoi_do      (eoi_do),
        .eoi_vec     (eoi_vec),
        .irr         (irr),
        .isr         (isr),
        .inj_was_set (inj_was_set),
        .eoi_trig    (eoi_trig)
    );
endmodule

// File: rtl/vpc_checker.sv
// Module: property checker for the vector controller, attached by bind below.
// Assumes: the same clock and synchronous active-low reset as the design.
module vpc_checker #(
    parameter int VEC_W      = vpc_pkg::VEC_W,
    parameter int CLASS_W    = vpc_pkg::CLASS_W,
    parameter int RSVD_LIMIT = vpc_pkg::RSVD_LIMIT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_en,
    input logic             inj_valid,
    input logic             inj_ok,
    input logic             inj_err,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vec,
    input logic [VEC_W-1:0] proc_prio,
    input logic             ack,
    input logic             eoi,
    input logic             eoi_valid,
    input logic [VEC_W-1:0] eoi_vec
);
    localparam int SUB_W = VEC_W - CLASS_W;

    logic rst_seen_q;

    // Purpose: remember that the previous cycle was in reset.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1: the first cycle after reset shows cleared state.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen_q |-> (proc_prio == '0 && !irq_valid));

    // R2: nothing is offered or accepted without the hardware enable.
    p_hw_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en |-> (!irq_valid && !inj_ok));

    // R4: a reserved injection is never accepted and no reserved vector is offered.
    p_rsvd_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inj_err |-> (inj_valid && !inj_ok));
    p_no_rsvd_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vec >= VEC_W'(RSVD_LIMIT)));

    // R6: an offered vector's class is above the processor priority.
    p_offer_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ({irq_vec[VEC_W-1:SUB_W], {SUB_W{1'b0}}} > proc_prio));

    // R7: after an acknowledge the priority reaches at least the taken class.
    p_ack_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && ack && !eoi) |=>
            (proc_prio[VEC_W-1:SUB_W] >= $past(irq_vec[VEC_W-1:SUB_W])));

    // R8: a retirement needs a strobe and never names a reserved vector.
    p_eoi_sane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (eoi && eoi_vec >= VEC_W'(RSVD_LIMIT)));
endmodule

bind vec_prio_ctrl vpc_checker #(
    .VEC_W      (VEC_W),
    .CLASS_W    (CLASS_W),
    .RSVD_LIMIT (RSVD_LIMIT)
) u_vpc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_en     (hw_en),
    .inj_valid (inj_valid),
    .inj_ok    (inj_ok),
    .inj_err   (inj_err),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .proc_prio (proc_prio),
    .ack       (ack),
    .eoi       (eoi),
    .eoi_valid (eoi_valid),
    .eoi_vec   (eoi_vec)
);

// File: tb/vec_prio_ctrl_test.sv
// Bench: table-driven sequence followed by directed reset and corner tests.
module vec_prio_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, hw_en, cfg_we, tpr_we, inj_valid, inj_level, ack, eoi;
    logic [9:0] cfg_wdata;
    logic [7:0] tpr_wdata, inj_vec;
    logic       inj_ok, inj_err, irq_valid, eoi_valid, eoi_level;
    logic [7:0] irq_vec, proc_prio, eoi_vec;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .inj_valid(inj_valid), .inj_vec(inj_vec),
        .inj_level(inj_level), .inj_ok(inj_ok), .inj_err(inj_err), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .proc_prio(proc_prio), .ack(ack), .eoi(eoi),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .eoi_level(eoi_level)
    );

    typedef struct packed {
        logic       inj;
        logic [7:0] vec;
        logic       lvl;
        logic       ack;
        logic       eoi;
        logic       e_valid;
        logic [7:0] e_vec;
        logic [7:0] e_prio;
    } row_t;

    // Applied in order from an enabled, empty state with task priority 0.
    localparam row_t TBL [12] = '{
        '{1'b1, 8'h45, 1'b0, 1'b0, 1'b0, 1'b1, 8'h45, 8'h00},
        '{1'b1, 8'h82, 1'b1, 1'b0, 1'b0, 1'b1, 8'h82, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h80},
        '{1'b1, 8'h91, 1'b0, 1'b0, 1'b0, 1'b1, 8'h91, 8'h80},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h90},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h80},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h45, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h40},
        '{1'b1, 8'h4A, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h40},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h4A, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00},
        '{1'b1, 8'h20, 1'b1, 1'b1, 1'b0, 1'b1, 8'h20, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_we = 0; tpr_we = 0; inj_valid = 0; inj_level = 0; ack = 0; eoi = 0;
        inj_vec = 8'h00; cfg_wdata = '0; tpr_wdata = '0;
    endtask

    task automatic inject(input logic [7:0] v, input logic lvl, input logic exp_ok, input string req);
        inj_valid = 1; inj_vec = v; inj_level = lvl;
        #1 check(req, inj_ok, exp_ok);
        step(); idle(); #1;
    endtask

    task automatic set_tpr(input logic [7:0] t);
        tpr_we = 1; tpr_wdata = t;
        step(); idle(); #1;
    endtask

    task automatic take_and_retire(input logic [7:0] exp_vec, input logic exp_lvl, input string req);
        ack = 1;
        step(); idle();
        eoi = 1;
        #1 check(req, eoi_valid, 1'b1);
        check(req, eoi_vec, exp_vec);
        check(req, eoi_level, exp_lvl);
        step(); idle(); #1;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle(); hw_en = 1; rst_n = 0;
        @(negedge clk); step(); rst_n = 1; #1;
        // R1: reset state
        check("R1 irq_valid", irq_valid, 1'b0);
        check("R1 proc_prio", proc_prio, 8'h00);
        // R1/R2: software enable cleared by reset, so injection is dropped
        inject(8'h50, 1'b0, 1'b0, "R2 inj_ok sw off");
        check("R2 irq_valid sw off", irq_valid, 1'b0);

        cfg_we = 1; cfg_wdata = 10'h100; step(); idle(); #1;

        // Table walk: R3 R5 R6 R7 R8 R9
        for (int i = 0; i < 12; i++) begin
            inj_valid = TBL[i].inj; inj_vec = TBL[i].vec; inj_level = TBL[i].lvl;
            ack = TBL[i].ack; eoi = TBL[i].eoi;
            step(); idle(); #1;
            check($sformatf("R6 row%0d irq_valid", i), irq_valid, TBL[i].e_valid);
            if (TBL[i].e_valid) check($sformatf("R6 row%0d irq_vec", i), irq_vec, TBL[i].e_vec);
            check($sformatf("R5 row%0d proc_prio", i), proc_prio, TBL[i].e_prio);
        end

        // R8: level vector 0x20 retires with level flag, then empty retire has no effect
        take_and_retire(8'h20, 1'b1, "R8 retire level");
        eoi = 1;
        #1 check("R8 empty eoi_valid", eoi_valid, 1'b0);
        step(); idle(); #1;
        check("R8 empty proc_prio", proc_prio, 8'h00);
        check("R8 empty irq_valid", irq_valid, 1'b0);

        // R3: repeated requests and trigger bits
        inject(8'h70, 1'b1, 1'b1, "R3 first level");
        inject(8'h70, 1'b1, 1'b0, "R3 repeat level");
        take_and_retire(8'h70, 1'b1, "R3 level kept");
        inject(8'h71, 1'b1, 1'b1, "R3 first level 71");
        inject(8'h71, 1'b0, 1'b0, "R3 repeat edge");
        take_and_retire(8'h71, 1'b0, "R3 edge clears trig");
        inject(8'h72, 1'b0, 1'b1, "R3 first edge 72");
        inject(8'h72, 1'b1, 1'b0, "R3 repeat level no change");
        take_and_retire(8'h72, 1'b0, "R3 trig unchanged");

        // R4: reserved boundary
        inj_valid = 1; inj_vec = 8'h0F; inj_level = 0;
        #1 check("R4 err 0F", inj_err, 1'b1);
        check("R4 ok 0F", inj_ok, 1'b0);
        step(); idle(); #1;
        check("R4 0F not pending", irq_valid, 1'b0);
        inj_valid = 1; inj_vec = 8'h10;
        #1 check("R4 err 10", inj_err, 1'b0);
        step(); idle(); #1;
        check("R4 10 offered", irq_vec, 8'h10);
        check("R4 10 valid", irq_valid, 1'b1);
        take_and_retire(8'h10, 1'b0, "R4 retire 10");

        // R5: task priority paths
        set_tpr(8'h55);
        check("R5 tpr only", proc_prio, 8'h55);
        inject(8'h52, 1'b0, 1'b1, "R5 inj 52");
        check("R6 52 blocked", irq_valid, 1'b0);
        inject(8'h61, 1'b0, 1'b1, "R5 inj 61");
        check("R6 61 offered", irq_vec, 8'h61);
        ack = 1; step(); idle(); #1;
        check("R5 isr class wins", proc_prio, 8'h60);
        set_tpr(8'h7A);
        check("R5 tpr wins", proc_prio, 8'h7A);
        set_tpr(8'h55);
        eoi = 1; step(); idle(); #1;
        check("R5 back to tpr", proc_prio, 8'h55);
        check("R6 52 still blocked", irq_valid, 1'b0);
        set_tpr(8'h00);
        check("R6 52 released", irq_vec, 8'h52);
        check("R6 52 valid", irq_valid, 1'b1);
        take_and_retire(8'h52, 1'b0, "R7 retire 52");

        // R9: inject and acknowledge the same vector in one cycle
        inject(8'h33, 1'b0, 1'b1, "R9 first 33");
        inj_valid = 1; inj_vec = 8'h33; inj_level = 0; ack = 1;
        #1 check("R9 reinject ok", inj_ok, 1'b0);
        step(); idle(); #1;
        check("R9 prio after", proc_prio, 8'h30);
        check("R9 not pending", irq_valid, 1'b0);
        eoi = 1; step(); idle(); #1;
        check("R9 cleared", proc_prio, 8'h00);
        check("R9 nothing left", irq_valid, 1'b0);

        // R7: acknowledge with nothing offered has no effect
        ack = 1; step(); idle(); #1;
        check("R7 idle ack prio", proc_prio, 8'h00);

        // R2: enables
        hw_en = 0;
        inject(8'h90, 1'b0, 1'b0, "R2 hw off inj");
        hw_en = 1; #1;
        check("R2 hw off dropped", irq_valid, 1'b0);
        inject(8'h90, 1'b0, 1'b1, "R2 inj 90");
        hw_en = 0; #1;
        check("R2 hw off hides", irq_valid, 1'b0);
        hw_en = 1; #1;
        check("R2 hw on shows", irq_vec, 8'h90);
        cfg_we = 1; cfg_wdata = 10'h0FF; step(); idle(); #1;
        check("R2 sw off hides", irq_valid, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule